// File: doc/BRIEF.md
# Audio Serial Clock and Frame Sync Generator

This block produces the serial bit clock and the two frame-sync clocks, one for transmit and one for receive, that an audio serial formatter needs. It works from a fast master audio clock. In master role, a programmable divider turns the master clock into the bit clock. Two further dividers, one per direction, count bit clocks and form the frame-sync clocks. In slave role the dividers stop. The bit clock and frame-sync clocks supplied from outside pass through a two-flop synchronizer to the same outputs.

Every divider setting is written as the ratio minus one. A typical setup uses a master clock at 256 times the sample rate and 32-bit stereo slots. That gives a bit clock at 64 times the sample rate, so the bit divider field is 3 and the frame field is 63. A polarity input inverts the bit clock at the pin. Alongside the clocks, the block emits single-cycle strobes in the master clock domain: one marks each bit-clock edge and one marks each frame start. The formatter uses these strobes instead of clocking on the derived clocks.

A new divider setting never cuts a clock phase short. Frame dividers pick up a new length only when a frame wraps. The bit divider picks up a new ratio at the first bit period that begins after the transmit frame wraps.

Top module: `audclk_gen`

## Requirements
- R1: In master role the bit clock period is max(bclk_div_m1+1, 2) master clock cycles.
- R2: With bclk_invert=0 the bit clock is high for floor(P/2) and low for P-floor(P/2) cycles of each period P, so an odd ratio gives a high phase one cycle shorter than the low phase.
- R3: bclk_rise_stb is high only in the first cycle in which bclk_out reads 1 after reading 0, and bclk_fall_stb is high only in the first cycle in which bclk_out reads 0 after reading 1. The two are never high together, and bclk_out never changes without one of them.
- R4: bclk_invert=1 inverts bclk_out in both roles. The edge strobes describe the inverted pin, so the period keeps its length while the high and low phases swap. While reset is held, bclk_out equals bclk_invert.
- R5: In master role a frame lasts max(len+1, 2) bit periods, where len is that direction's frame field. The frame clock is low for the first floor(bits/2) bit periods and high for the rest. It changes one master cycle after a cycle with bclk_fall_stb high.
- R6: Transmit and receive frames are counted independently from tx_frame_m1 and rx_frame_m1. In slave role each direction follows only its own external frame clock.
- R7: Each frame strobe is one master cycle wide and falls in the first cycle in which its frame clock output is low.
- R8: A frame field changed in the middle of a frame leaves that frame at its old length. The new length applies from the next frame.
- R9: A bit divider change applies from the first bit period that begins after the transmit frame wraps. Bit periods before that keep the old ratio.
- R10: In slave role (mode_slave=1) the master dividers are idle. bclk_out, tx_lrck_out and rx_lrck_out follow their external inputs two master clock edges after those inputs are sampled. Bit-clock strobes mark edges of the synchronized clock, and a frame strobe marks a falling edge of the synchronized frame clock.
- R11: During reset the frame clocks read 1 and all strobes read 0. In master role the first cycle after reset is a rising edge of the internal bit clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master audio clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_slave | input | 1 | 0: generate clocks locally; 1: use external clocks |
| bclk_invert | input | 1 | Inverts the bit clock at the pin |
| bclk_div_m1 | input | DIV_W | Master-to-bit-clock ratio minus one |
| tx_frame_m1 | input | FRAME_W | Bit clocks per transmit frame minus one |
| rx_frame_m1 | input | FRAME_W | Bit clocks per receive frame minus one |
| ext_bclk | input | 1 | External bit clock (slave role) |
| ext_tx_lrck | input | 1 | External transmit frame clock (slave role) |
| ext_rx_lrck | input | 1 | External receive frame clock (slave role) |
| bclk_out | output | 1 | Bit clock |
| bclk_rise_stb | output | 1 | One-cycle strobe on a rising edge of bclk_out |
| bclk_fall_stb | output | 1 | One-cycle strobe on a falling edge of bclk_out |
| tx_lrck_out | output | 1 | Transmit frame clock |
| tx_frame_stb | output | 1 | One-cycle transmit frame start strobe |
| rx_lrck_out | output | 1 | Receive frame clock |
| rx_frame_stb | output | 1 | One-cycle receive frame start strobe |

## Verification
The bench builds the block with its default 8-bit divider fields and a two-stage synchronizer. It then programs short ratios through the fields: bit ratios of 2, 4, 5 and 9, and frames of 4, 7 and 8 bits. At these settings every frame finishes in a few dozen master cycles. The odd-ratio split, the odd-length frame, and the zero field clamped to the minimum ratio can each be checked over complete periods. The same short frames let a mid-frame change of a frame length or a bit ratio be followed across the boundary where it takes hold.

// File: rtl/audclk_pkg.sv
package audclk_pkg;

    // Clock role selected by the mode input
    typedef enum logic {
        CLK_MASTER = 1'b0,
        CLK_SLAVE  = 1'b1
    } clk_role_e;

    // Level and edge view of a bit clock, all in the master clock domain
    typedef struct packed {
        logic level;
        logic rise;
        logic fall;
    } clk_view_t;

    // Direction indices for the per-direction frame logic
    localparam int unsigned DIR_TX = 0;
    localparam int unsigned DIR_RX = 1;
    localparam int unsigned N_DIR  = 2;

    // Turn a pin-level view into its inverted twin (edges swap)
    function automatic clk_view_t flip_view(clk_view_t v, logic inv);
        clk_view_t r;
        r.level = v.level ^ inv;
        r.rise  = inv ? v.fall : v.rise;
        r.fall  = inv ? v.rise : v.fall;
        return r;
    endfunction

endpackage

// File: rtl/audclk_bitdiv.sv
module audclk_bitdiv #(
    parameter int unsigned W = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  enable,
    input  logic [W-1:0]          div_m1,
    input  logic                  apply_req,
    output audclk_pkg::clk_view_t view
);
    import audclk_pkg::*;

    logic [W-1:0] cnt_q, cnt_n;
    logic [W-1:0] last_q, last_n, req_last;
    logic [W:0]   half_n;
    logic         run_q, pend_q, pend_n;
    logic         wrap, take;

    always_comb begin
        // A zero field would give a ratio of one; clamp to the smallest usable ratio
        req_last = (div_m1 == '0) ? W'(1) : div_m1;
        wrap     = !run_q || (cnt_q >= last_q);
        take     = wrap && (!run_q || pend_q || apply_req);
        last_n   = take ? req_last : last_q;
        cnt_n    = wrap ? '0 : cnt_q + 1'b1;
        pend_n   = take ? 1'b0 : (pend_q || apply_req);
        half_n   = ({1'b0, last_n} + 1'b1) >> 1;
    end

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            run_q  <= 1'b0;
            cnt_q  <= '0;
            last_q <= req_last;
            pend_q <= 1'b0;
            view   <= '0;
        end else begin
            run_q      <= 1'b1;
            cnt_q      <= cnt_n;
            last_q     <= last_n;
            pend_q     <= pend_n;
            view.level <= ({1'b0, cnt_n} < half_n);
            view.rise  <= (cnt_n == '0);
            view.fall  <= ({1'b0, cnt_n} == half_n);
        end
    end

endmodule

// File: rtl/audclk_framediv.sv
module audclk_framediv #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         enable,
    input  logic         advance,
    input  logic [W-1:0] len_m1,
    output logic         lrck,
    output logic         frame_stb,
    output logic         wrap_evt
);
    logic [W-1:0] cnt_q, cnt_n;
    logic [W-1:0] last_q, last_n, req_last;
    logic [W:0]   half_n;
    logic         wrap;

    always_comb begin
        req_last = (len_m1 == '0) ? W'(1) : len_m1;
        wrap     = (cnt_q >= last_q);
        wrap_evt = enable && advance && wrap;
        cnt_n    = wrap ? '0 : cnt_q + 1'b1;
        last_n   = wrap ? req_last : last_q;
        half_n   = ({1'b0, last_n} + 1'b1) >> 1;
    end

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            cnt_q     <= '1;
            last_q    <= req_last;
            lrck      <= 1'b1;
            frame_stb <= 1'b0;
        end else begin
            frame_stb <= advance && wrap;
            if (advance) begin
                cnt_q  <= cnt_n;
                last_q <= last_n;
                lrck   <= ({1'b0, cnt_n} >= half_n);
            end
        end
    end

endmodule

// File: rtl/audclk_sync_edge.sv
module audclk_sync_edge #(
    parameter int unsigned STAGES  = 2,
    parameter logic        RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic level,
    output logic prev
);
    // STAGES synchronizer flops plus one history flop for edge detection
    logic [STAGES:0] chain;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= {(STAGES+1){RST_VAL}};
        end else begin
            chain <= {chain[STAGES-1:0], async_in};
        end
    end

    assign level = chain[STAGES-1];
    assign prev  = chain[STAGES];

endmodule

// File: rtl/audclk_gen.sv
module audclk_gen #(
    parameter int unsigned DIV_W       = 8,
    parameter int unsigned FRAME_W     = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               mode_slave,
    input  logic               bclk_invert,
    input  logic [DIV_W-1:0]   bclk_div_m1,
    input  logic [FRAME_W-1:0] tx_frame_m1,
    input  logic [FRAME_W-1:0] rx_frame_m1,
    input  logic               ext_bclk,
    input  logic               ext_tx_lrck,
    input  logic               ext_rx_lrck,
    output logic               bclk_out,
    output logic               bclk_rise_stb,
    output logic               bclk_fall_stb,
    output logic               tx_lrck_out,
    output logic               tx_frame_stb,
    output logic               rx_lrck_out,
    output logic               rx_frame_stb
);
    import audclk_pkg::*;

    clk_role_e role;
    logic      master_en;
    clk_view_t mst_raw, mst_pin, slv_pin, pin;
    logic      sb_level, sb_prev;
    logic      launch;

    logic [FRAME_W-1:0] len_arr [N_DIR];
    logic [N_DIR-1:0]   ext_lr, m_lrck, m_stb, m_wrap, s_lvl, s_prev;

    assign role      = clk_role_e'(mode_slave);
    assign master_en = (role == CLK_MASTER);

    // Local bit clock generation
    audclk_bitdiv #(.W(DIV_W)) u_bitdiv (
        .clk       (clk),
        .rst       (rst),
        .enable    (master_en),
        .div_m1    (bclk_div_m1),
        .apply_req (m_wrap[DIR_TX]),
        .view      (mst_raw)
    );

    // External bit clock path
    audclk_sync_edge #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_bclk (
        .clk      (clk),
        .rst      (rst),
        .async_in (ext_bclk),
        .level    (sb_level),
        .prev     (sb_prev)
    );

    always_comb begin
        mst_pin      = flip_view(mst_raw, bclk_invert);
        slv_pin.level = sb_level ^ bclk_invert;
        slv_pin.rise  = slv_pin.level & ~(sb_prev ^ bclk_invert);
        slv_pin.fall  = ~slv_pin.level & (sb_prev ^ bclk_invert);
        pin           = master_en ? mst_pin : slv_pin;
        // Frames advance on the falling edge of the bit clock as seen at the pin
        launch        = mst_pin.fall;
    end

    assign len_arr[DIR_TX] = tx_frame_m1;
    assign len_arr[DIR_RX] = rx_frame_m1;
    assign ext_lr[DIR_TX]  = ext_tx_lrck;
    assign ext_lr[DIR_RX]  = ext_rx_lrck;

    for (genvar d = 0; d < N_DIR; d++) begin : g_dir
        audclk_framediv #(.W(FRAME_W)) u_framediv (
            .clk       (clk),
            .rst       (rst),
            .enable    (master_en),
            .advance   (launch),
            .len_m1    (len_arr[d]),
            .lrck      (m_lrck[d]),
            .frame_stb (m_stb[d]),
            .wrap_evt  (m_wrap[d])
        );

        audclk_sync_edge #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_lr (
            .clk      (clk),
            .rst      (rst),
            .async_in (ext_lr[d]),
            .level    (s_lvl[d]),
            .prev     (s_prev[d])
        );
    end

    assign bclk_out      = pin.level;
    assign bclk_rise_stb = pin.rise;
    assign bclk_fall_stb = pin.fall;

    assign tx_lrck_out  = master_en ? m_lrck[DIR_TX] : s_lvl[DIR_TX];
    assign tx_frame_stb = master_en ? m_stb[DIR_TX]  : (s_prev[DIR_TX] & ~s_lvl[DIR_TX]);
    assign rx_lrck_out  = master_en ? m_lrck[DIR_RX] : s_lvl[DIR_RX];
    assign rx_frame_stb = master_en ? m_stb[DIR_RX]  : (s_prev[DIR_RX] & ~s_lvl[DIR_RX]);

endmodule

// File: rtl/audclk_chk.sv
module audclk_chk (
    input logic clk,
    input logic rst,
    input logic mode_slave,
    input logic bclk_invert,
    input logic bclk_out,
    input logic bclk_rise_stb,
    input logic bclk_fall_stb,
    input logic tx_lrck_out,
    input logic tx_frame_stb,
    input logic rx_lrck_out,
    input logic rx_frame_stb
);

    // R3
    rise_level_chk: assert property (@(posedge clk) disable iff (rst)
        bclk_rise_stb |-> bclk_out);

    // R3
    fall_level_chk: assert property (@(posedge clk) disable iff (rst)
        bclk_fall_stb |-> !bclk_out);

    // R3
    edge_excl_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({bclk_rise_stb, bclk_fall_stb}));

    // R3
    pin_change_chk: assert property (@(posedge clk) disable iff (rst)
        ($stable(bclk_invert) && $stable(mode_slave) && (bclk_out != $past(bclk_out)))
        |-> (bclk_rise_stb || bclk_fall_stb));

    // R7
    tx_start_low_chk: assert property (@(posedge clk) disable iff (rst)
        tx_frame_stb |-> !tx_lrck_out);

    // R7
    rx_start_low_chk: assert property (@(posedge clk) disable iff (rst)
        rx_frame_stb |-> !rx_lrck_out);

    // R7
    tx_stb_width_chk: assert property (@(posedge clk) disable iff (rst)
        tx_frame_stb |=> !tx_frame_stb);

    // R7
    rx_stb_width_chk: assert property (@(posedge clk) disable iff (rst)
        rx_frame_stb |=> !rx_frame_stb);

    // R5
    tx_lr_launch_chk: assert property (@(posedge clk) disable iff (rst)
        (!mode_slave && $stable(mode_slave) && $stable(bclk_invert)
         && (tx_lrck_out != $past(tx_lrck_out))) |-> $past(bclk_fall_stb));

    // R5
    rx_lr_launch_chk: assert property (@(posedge clk) disable iff (rst)
        (!mode_slave && $stable(mode_slave) && $stable(bclk_invert)
         && (rx_lrck_out != $past(rx_lrck_out))) |-> $past(bclk_fall_stb));

endmodule

bind audclk_gen audclk_chk u_chk (.*);

// File: tb/tb_audclk_gen.sv
module tb_audclk_gen;

    logic       clk = 1'b0;
    logic       rst;
    logic       mode_slave, bclk_invert;
    logic [7:0] bclk_div_m1, tx_frame_m1, rx_frame_m1;
    logic       ext_bclk, ext_tx_lrck, ext_rx_lrck;
    logic       bclk_out, bclk_rise_stb, bclk_fall_stb;
    logic       tx_lrck_out, tx_frame_stb, rx_lrck_out, rx_frame_stb;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    audclk_gen dut (
        .clk           (clk),
        .rst           (rst),
        .mode_slave    (mode_slave),
        .bclk_invert   (bclk_invert),
        .bclk_div_m1   (bclk_div_m1),
        .tx_frame_m1   (tx_frame_m1),
        .rx_frame_m1   (rx_frame_m1),
        .ext_bclk      (ext_bclk),
        .ext_tx_lrck   (ext_tx_lrck),
        .ext_rx_lrck   (ext_rx_lrck),
        .bclk_out      (bclk_out),
        .bclk_rise_stb (bclk_rise_stb),
        .bclk_fall_stb (bclk_fall_stb),
        .tx_lrck_out   (tx_lrck_out),
        .tx_frame_stb  (tx_frame_stb),
        .rx_lrck_out   (rx_lrck_out),
        .rx_frame_stb  (rx_frame_stb)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check_eq(string req, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) tick();
        rst = 1'b0;
    endtask

    function automatic logic fstb(bit rx);
        return rx ? rx_frame_stb : tx_frame_stb;
    endfunction

    function automatic logic flr(bit rx);
        return rx ? rx_lrck_out : tx_lrck_out;
    endfunction

    // Moves to the next rise strobe, then measures one full bit period
    task automatic meas_bit(output int per, output int hi);
        int g = 0;
        do begin tick(); g++; end while (!bclk_rise_stb && g < 2000);
        per = 0;
        hi  = 0;
        do begin
            if (bclk_out) hi++;
            per++;
            tick();
        end while (!bclk_rise_stb && per < 2000);
    endtask

    // Moves to the next frame strobe, then measures one frame
    task automatic meas_frame(input bit rx, output int per, output int low);
        int g = 0;
        do begin tick(); g++; end while (!fstb(rx) && g < 4000);
        per = 0;
        low = 0;
        do begin
            if (!flr(rx)) low++;
            per++;
            tick();
        end while (!fstb(rx) && per < 4000);
    endtask

    task automatic set_cfg(bit slave, bit inv, int div, int txl, int rxl);
        mode_slave  = slave;
        bclk_invert = inv;
        bclk_div_m1 = 8'(div);
        tx_frame_m1 = 8'(txl);
        rx_frame_m1 = 8'(rxl);
    endtask

    task automatic t_reset();
        set_cfg(0, 0, 3, 63, 63);
        rst = 1'b1;
        repeat (2) tick();
        check_eq("R11", "bclk_out in reset", int'(bclk_out), 0);
        check_eq("R11", "tx_lrck in reset", int'(tx_lrck_out), 1);
        check_eq("R11", "rx_lrck in reset", int'(rx_lrck_out), 1);
        check_eq("R11", "strobes in reset",
                 int'({bclk_rise_stb, bclk_fall_stb, tx_frame_stb, rx_frame_stb}), 0);
        rst = 1'b0;
        tick();
        check_eq("R11", "rise strobe first cycle", int'(bclk_rise_stb), 1);
        check_eq("R11", "bclk high first cycle", int'(bclk_out), 1);
    endtask

    task automatic t_ratio(int div, int exp_per, int exp_hi);
        int per, hi;
        set_cfg(0, 0, div, 63, 63);
        do_reset();
        meas_bit(per, hi);
        check_eq("R1", $sformatf("period div_m1=%0d", div), per, exp_per);
        check_eq("R2", $sformatf("high phase div_m1=%0d", div), hi, exp_hi);
    endtask

    task automatic t_polarity();
        int per, hi;
        set_cfg(0, 1, 4, 63, 63);
        rst = 1'b1;
        repeat (2) tick();
        check_eq("R4", "inverted bclk in reset", int'(bclk_out), 1);
        rst = 1'b0;
        tick();
        check_eq("R4", "inverted first cycle fall strobe", int'(bclk_fall_stb), 1);
        check_eq("R4", "inverted first cycle level", int'(bclk_out), 0);
        meas_bit(per, hi);
        check_eq("R4", "inverted period", per, 5);
        check_eq("R4", "inverted high phase", hi, 3);
    endtask

    task automatic t_frame();
        int per, low;
        set_cfg(0, 0, 1, 7, 6);
        do_reset();
        meas_frame(0, per, low);
        check_eq("R5", "tx frame length", per, 16);
        check_eq("R5", "tx low half", low, 8);
        meas_frame(1, per, low);
        check_eq("R6", "rx frame length (7 bits)", per, 14);
        check_eq("R6", "rx low part", low, 6);
    endtask

    task automatic t_frame_change();
        int n, g;
        set_cfg(0, 0, 1, 7, 63);
        do_reset();
        g = 0;
        do begin tick(); g++; end while (!tx_frame_stb && g < 2000);
        n = 0;
        do begin
            tick();
            n++;
            if (n == 2) tx_frame_m1 = 8'd3;
        end while (!tx_frame_stb && n < 2000);
        check_eq("R8", "frame keeps old length", n, 16);
        n = 0;
        do begin tick(); n++; end while (!tx_frame_stb && n < 2000);
        check_eq("R8", "next frame new length", n, 8);
    endtask

    task automatic t_bit_change();
        int per, hi, g;
        set_cfg(0, 0, 3, 3, 63);
        do_reset();
        g = 0;
        do begin tick(); g++; end while (!tx_frame_stb && g < 2000);
        repeat (2) tick();
        bclk_div_m1 = 8'd1;
        meas_bit(per, hi);
        check_eq("R9", "old ratio before frame start", per, 4);
        g = 0;
        do begin tick(); g++; end while (!tx_frame_stb && g < 2000);
        meas_bit(per, hi);
        check_eq("R9", "new ratio after frame start", per, 2);
        check_eq("R9", "new ratio high phase", hi, 1);
    endtask

    task automatic t_slave();
        int rises = 0;
        set_cfg(1, 0, 3, 63, 63);
        ext_bclk = 1'b0; ext_tx_lrck = 1'b1; ext_rx_lrck = 1'b1;
        do_reset();
        for (int i = 0; i < 20; i++) begin
            tick();
            if (bclk_rise_stb) rises++;
        end
        check_eq("R10", "dividers idle in slave", rises, 0);
        ext_bclk = 1'b1;
        tick();
        check_eq("R10", "bclk after one edge", int'(bclk_out), 0);
        tick();
        check_eq("R10", "bclk after two edges", int'(bclk_out), 1);
        check_eq("R10", "slave rise strobe", int'(bclk_rise_stb), 1);
        tick();
        check_eq("R10", "slave rise strobe one cycle", int'(bclk_rise_stb), 0);
        ext_bclk = 1'b0;
        repeat (2) tick();
        check_eq("R10", "slave fall strobe", int'(bclk_fall_stb), 1);
        ext_tx_lrck = 1'b0;
        tick();
        check_eq("R10", "tx strobe not yet", int'(tx_frame_stb), 0);
        tick();
        check_eq("R10", "tx frame strobe", int'(tx_frame_stb), 1);
        check_eq("R10", "tx lrck follows", int'(tx_lrck_out), 0);
        check_eq("R6", "rx untouched strobe", int'(rx_frame_stb), 0);
        check_eq("R6", "rx untouched lrck", int'(rx_lrck_out), 1);
        tick();
        check_eq("R7", "slave tx strobe one cycle", int'(tx_frame_stb), 0);
        bclk_invert = 1'b1;
        tick();
        check_eq("R4", "slave inverted bclk", int'(bclk_out), 1);
    endtask

    initial begin
        rst = 1'b1;
        set_cfg(0, 0, 3, 63, 63);
        ext_bclk = 1'b0; ext_tx_lrck = 1'b1; ext_rx_lrck = 1'b1;
        t_reset();
        t_ratio(3, 4, 2);
        t_ratio(4, 5, 2);
        t_ratio(0, 2, 1);
        t_ratio(8, 9, 4);
        t_polarity();
        t_frame();
        t_frame_change();
        t_bit_change();
        t_slave();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL R1 watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule